// File: doc/BRIEF.md
# Selectable Output Data Rate Tick Generator

This block paces a sensor front end. From the system clock it derives a one-cycle sample strobe whose rate is chosen by a 3-bit rate code. The rate ladder is not uniform. It halves from 800 Hz down to 50 Hz, then drops more steeply to 12.5, 6.25 and 1.5625 Hz.

When the combined (two-sensor) mode is on, each output period is split into two equal slots. The first slot is for the accelerometer conversion and the second is for the magnetometer conversion. This doubles every output period. A slot flag tells downstream logic which conversion the current slot belongs to.

While the device is in standby the block is silent and its counter is held at zero. A new rate code or mode setting is captured only at the end of an output period, so a period already under way always finishes at its old length.

The clock-cycle counts come from two parameters. `CLK_HZ` is the clock frequency. `RATE_STEP_HZ` is the fastest single-sensor rate, 800 Hz. One base step of `CLK_HZ/RATE_STEP_HZ` cycles equals 1.25 ms.

Top module: `odr_tick`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `strobe` and `slot` are both 0.
- R2: In single-sensor mode (`hybrid`=0), the spacing between strobes is N base steps. N is 1, 2, 4, 8, 16, 64, 128 and 512 for `rate_code` values 0 to 7. Code 0 is 800 Hz and code 7 is 1.5625 Hz.
- R3: In combined mode (`hybrid`=1), every code gives twice the single-sensor spacing, which halves the rate. For example, code 7 gives 1024 base steps.
- R4: While `active` is 0, no strobe is produced. After `active` rises, the first strobe arrives exactly one full output period later.
- R5: `strobe` is high for exactly one clock cycle per period. This assumes a base step of at least two clock cycles.
- R6: In combined mode, `slot` is 0 during the first half of each output period and 1 during the second half. It is 0 in the cycle that `strobe` is high. In single-sensor mode `slot` stays 0.
- R7: A change of `rate_code` during a period does not alter that period. The new code governs from the next period onward.
- R8: A change of `hybrid` during a period does not alter that period. The new mode governs from the next period onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active | input | 1 | 1 = active, 0 = standby |
| hybrid | input | 1 | 1 = combined two-sensor mode |
| rate_code | input | 3 | Output data rate selection |
| strobe | output | 1 | One-cycle sample strobe at the end of each output period |
| slot | output | 1 | Combined mode: 0 = accelerometer slot, 1 = magnetometer slot |

## Verification
A wrong period count shows up at the strobe spacing one period after activation. With the default parameters that is 10 to 10240 cycles, depending on the code and mode. A phase bit that is stuck or flipped shows up within one combined period: `slot` then spends the wrong number of cycles high, or is high when the strobe fires. A reload at the wrong moment shows up within two periods. The interrupted period has the wrong length, or the period after it keeps the old rate.

// File: rtl/odr_tick.sv
module odr_tick #(
  parameter int unsigned CLK_HZ       = 8000,
  parameter int unsigned RATE_STEP_HZ = 800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       hybrid,
  input  logic [2:0] rate_code,
  output logic       strobe,
  output logic       slot
);

  localparam int unsigned UNIT    = CLK_HZ / RATE_STEP_HZ;
  localparam int unsigned MAX_CYC = UNIT * 512;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  function automatic int unsigned steps(input logic [2:0] c);
    case (c)
      3'd5:    steps = 64;
      3'd6:    steps = 128;
      3'd7:    steps = 512;
      default: steps = 32'd1 << c;
    endcase
  endfunction

  logic [CW-1:0] cnt, last;
  logic [2:0]    cur_code;
  logic          cur_hyb, phase;
  logic          expire, full;

  assign last   = CW'(UNIT * steps(cur_code) - 1);
  assign expire = (cnt == last);
  assign full   = expire && (!cur_hyb || phase);
  assign slot   = phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      phase    <= 1'b0;
      cur_code <= 3'd0;
      cur_hyb  <= 1'b0;
      strobe   <= 1'b0;
    end else if (!active) begin
      cnt      <= '0;
      phase    <= 1'b0;
      cur_code <= rate_code;
      cur_hyb  <= hybrid;
      strobe   <= 1'b0;
    end else begin
      strobe <= full;
      if (expire) begin
        cnt <= '0;
        if (full) begin
          phase    <= 1'b0;
          cur_code <= rate_code;
          cur_hyb  <= hybrid;
        end else begin
          phase <= 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

module odr_tick_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       active,
  input logic       strobe,
  input logic       slot,
  input logic       cur_hyb,
  input logic [2:0] cur_code
);

  // R4
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !strobe);

  // R5
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  // R6
  slot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_hyb |-> !slot);

  // R6
  slot_at_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> !slot);

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !strobe) |-> $stable(cur_code));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !strobe) |-> $stable(cur_hyb));

endmodule

bind odr_tick odr_tick_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .active   (active),
  .strobe   (strobe),
  .slot     (slot),
  .cur_hyb  (cur_hyb),
  .cur_code (cur_code)
);

// File: tb/odr_tick_test.sv
module odr_tick_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 8000;
  localparam int STEP_HZ    = 800;
  localparam int UNIT       = CLK_HZ / STEP_HZ;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       active = 1'b0;
  logic       hybrid = 1'b0;
  logic [2:0] rate_code = 3'd0;
  logic       strobe, slot;

  int errors = 0;
  int checks = 0;

  odr_tick #(.CLK_HZ(CLK_HZ), .RATE_STEP_HZ(STEP_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .active(active), .hybrid(hybrid),
    .rate_code(rate_code), .strobe(strobe), .slot(slot));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int steps(input int c);
    if (c < 5) return 1 << c;
    else if (c == 5) return 64;
    else if (c == 6) return 128;
    else return 512;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(output logic s, output logic sl);
    @(posedge clk);
    #1;
    s = strobe;
    sl = slot;
  endtask

  // samples until a strobe is seen; n counts samples including a start offset
  task automatic measure(input int start, output int n, output int hi);
    logic s, sl;
    n = start;
    hi = 0;
    do begin
      step(s, sl);
      n++;
      if (sl) hi++;
    end while (!s && n < 20000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, hi, seen;
    logic s, sl;

    repeat (3) @(posedge clk);
    #1;
    check("R1 strobe in reset", strobe, 0);
    check("R1 slot in reset", slot, 0);
    rst_n = 1'b1;
    step(s, sl);
    check("R1 strobe after reset", s, 0);
    check("R1 slot after reset", sl, 0);

    seen = 0;
    for (int i = 0; i < 100; i++) begin
      step(s, sl);
      if (s) seen++;
    end
    check("R4 standby strobes", seen, 0);

    for (int h = 0; h < 2; h++) begin
      for (int c = 0; c < 8; c++) begin
        int half;
        int per;
        half = steps(c) * UNIT;
        per  = half * (h + 1);
        hybrid = h[0];
        rate_code = c[2:0];
        step(s, sl);
        active = 1'b1;
        measure(0, n, hi);
        check($sformatf("R4 first latency h=%0d c=%0d", h, c), n, per);
        step(s, sl);
        check($sformatf("R5 pulse width h=%0d c=%0d", h, c), s, 0);
        measure(1, n, hi);
        if (h == 0) begin
          check($sformatf("R2 period c=%0d", c), n, per);
          check($sformatf("R6 single slot c=%0d", c), hi, 0);
        end else begin
          check($sformatf("R3 period c=%0d", c), n, per);
          check($sformatf("R6 hybrid slot c=%0d", c), hi, half);
        end
        active = 1'b0;
        step(s, sl);
        check($sformatf("R4 stop h=%0d c=%0d", h, c), s, 0);
      end
    end

    // R7: change code mid period
    hybrid = 1'b0;
    rate_code = 3'd2;
    step(s, sl);
    active = 1'b1;
    measure(0, n, hi);
    for (int i = 0; i < 10; i++) step(s, sl);
    rate_code = 3'd0;
    measure(10, n, hi);
    check("R7 period keeps old code", n, 4 * UNIT);
    measure(0, n, hi);
    check("R7 new code applied", n, UNIT);

    // R8: change mode mid period
    for (int i = 0; i < 3; i++) step(s, sl);
    hybrid = 1'b1;
    measure(3, n, hi);
    check("R8 period keeps single mode", n, UNIT);
    check("R8 slot stays low", hi, 0);
    measure(0, n, hi);
    check("R8 combined mode applied", n, 2 * UNIT);
    check("R8 combined slot", hi, UNIT);
    active = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule